// File: doc/BRIEF.md
# DMA Descriptor Command Sequencer

This block is the per-channel control engine of a descriptor-driven DMA channel. Software points it at a chain of 16-byte descriptors and starts it. The sequencer then fetches each descriptor and decodes its command word. Depending on the opcode, it hands a transfer or a device-register access to an external data mover, or it does nothing, or it halts.

Every command carries three 2-bit controls: wait, interrupt and branch. Each control is tested against a live condition bit, using a four-way encoding: never, if the condition is 1, if the condition is 0, or always. The wait control can hold the command before it completes. When the command completes, the block writes back the residual byte count and the channel status into the descriptor's last word. It raises the interrupt if the interrupt control asks for it. It then moves on, either to the next descriptor at pointer + 16 or to the address held in the descriptor's command-dependent field.

The descriptor arrives as one 128-bit little-endian word with these fields:

| Bits | Field |
|---|---|
| [15:0] | request count |
| [31:16] | command word |
| [63:32] | data address |
| [95:64] | command-dependent field |

Top module: `dma_cmd_seq`

## Requirements
- R1: After reset the channel is inactive. `active`, `fetch_req`, `mv_req`, `wb_valid` and `irq` are all 0.
- R2: A `run_req` pulse while inactive loads `cmd_ptr` from `ptr_init`, sets `active`, and requests a fetch at that pointer. A `run_req` while active is ignored, and the pointer only changes when a command completes.
- R3: Command bits [15:12] values 0–3 are transfers. The block asserts `mv_req` with `mv_op` = opcode, `mv_key` = command bits [10:8], `mv_addr` = the data address, and `mv_count` = the request count. Bit 0 of the opcode marks the "last" (end-marker) variant and bit 1 marks input direction.
- R4: Opcodes 4 (store word) and 5 (load word) use the mover with `mv_count` = 4 only when the key is 5 or greater. With a key below 5 the mover is skipped and zero bytes count as moved.
- R5: Opcode 6 (no-op) and opcodes 8–15 skip the mover and complete with zero bytes moved.
- R6: Opcode 7 (stop) drops `active` in the next cycle. A stop produces no write-back and no interrupt, and no fetch follows until the next `run_req`.
- R7: `irq` pulses together with `wb_valid` exactly when command bits [5:4] select it. The codes are 0 = never, 1 = condition is 1, 2 = condition is 0, 3 = always. The condition is sampled in the write-back cycle.
- R8: Command bits [3:2], with the same encoding, select a branch. On a branch the next fetch uses the low `AW` bits of the command-dependent field. Otherwise the next fetch uses `cmd_ptr` + 16, modulo 2^AW.
- R9: Command bits [1:0], with the same encoding, hold the command before write-back. The hold is re-evaluated every cycle, and write-back follows in the cycle after the condition releases.
- R10: Write-back is a one-cycle `wb_valid` with `wb_addr` = `cmd_ptr` + 12. `wb_data`[15:0] carries the residual, equal to the request count minus the bytes moved, floored at 0. `wb_data`[31:16] carries the status, equal to {1, 7'b0, `dev_stat`}.
- R11: `mv_req` and its fields are held until `mv_done` is seen. `mv_moved` is captured in that cycle.
- R12: At most one of `fetch_req`, `mv_req` and `wb_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Start pulse from software |
| ptr_init | input | AW | Starting descriptor address |
| cond | input | 1 | Condition bit for wait, interrupt and branch |
| dev_stat | input | 8 | Device status bits written back |
| active | output | 1 | Channel is running |
| cmd_ptr | output | AW | Current descriptor address |
| fetch_req | output | 1 | Requests the descriptor at `cmd_ptr` |
| desc_valid | input | 1 | Descriptor data is present |
| desc_data | input | 128 | Fetched descriptor, little-endian |
| mv_req | output | 1 | Mover request |
| mv_op | output | 3 | Operation for the mover |
| mv_key | output | 3 | Stream or space key |
| mv_addr | output | 32 | Data address |
| mv_count | output | 16 | Bytes to move |
| mv_done | input | 1 | Mover finished |
| mv_moved | input | 16 | Bytes actually moved |
| wb_valid | output | 1 | Write-back strobe |
| wb_addr | output | AW | Address of the residual/status word |
| wb_data | output | 32 | Residual in [15:0], status in [31:16] |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with `AW` = 16. At that width, one fall-through step takes the pointer from 0xFFF0 to 0x0000, so the wrap is reachable directly. The bench drives every one of the 16 opcode values against a stream key and a register key. It crosses all four interrupt codes, all four branch codes and both condition values. The wait hold, the stop-and-restart path and residual clamping are each driven explicitly, with the expected pointer and write-back word computed arithmetically.

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_req,
  input  logic [AW-1:0] ptr_init,
  input  logic          cond,
  input  logic [7:0]    dev_stat,
  output logic          active,
  output logic [AW-1:0] cmd_ptr,
  output logic          fetch_req,
  input  logic          desc_valid,
  input  logic [127:0]  desc_data,
  output logic          mv_req,
  output logic [2:0]    mv_op,
  output logic [2:0]    mv_key,
  output logic [31:0]   mv_addr,
  output logic [15:0]   mv_count,
  input  logic          mv_done,
  input  logic [15:0]   mv_moved,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [31:0]   wb_data,
  output logic          irq
);
  localparam logic [AW-1:0] STEP    = AW'(16);
  localparam logic [AW-1:0] RES_OFS = AW'(12);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EXEC, S_WAIT, S_WB} st_t;
  st_t st;

  logic [15:0] req_q, cmd_q, moved_q;
  logic [31:0] addr_q, dep_q;

  function automatic logic pick(input logic [1:0] m, input logic c);
    return (m == 2'd3) || (m == 2'd1 && c) || (m == 2'd2 && !c);
  endfunction

  wire [3:0] d_op    = desc_data[31:28];
  wire [2:0] d_key   = desc_data[26:24];
  wire       d_word  = (d_op == 4'd4) || (d_op == 4'd5);
  wire       d_mover = (d_op < 4'd4) || (d_word && d_key >= 3'd5);

  wire       hold    = pick(cmd_q[1:0], cond);
  wire       take_br = pick(cmd_q[3:2], cond);
  wire [15:0] resid  = (moved_q >= req_q) ? 16'd0 : req_q - moved_q;

  assign active    = (st != S_IDLE);
  assign fetch_req = (st == S_FETCH);
  assign mv_req    = (st == S_EXEC);
  assign wb_valid  = (st == S_WB);
  assign irq       = wb_valid && pick(cmd_q[5:4], cond);
  assign mv_op     = cmd_q[14:12];
  assign mv_key    = cmd_q[10:8];
  assign mv_addr   = addr_q;
  assign mv_count  = cmd_q[14] ? 16'd4 : req_q;
  assign wb_addr   = cmd_ptr + RES_OFS;
  assign wb_data   = {1'b1, 7'd0, dev_stat, resid};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_ptr <= '0;
      req_q   <= '0;
      cmd_q   <= '0;
      moved_q <= '0;
      addr_q  <= '0;
      dep_q   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (run_req) begin
          cmd_ptr <= ptr_init;
          st      <= S_FETCH;
        end
        S_FETCH: if (desc_valid) begin
          req_q  <= desc_data[15:0];
          cmd_q  <= desc_data[31:16];
          addr_q <= desc_data[63:32];
          dep_q  <= desc_data[95:64];
          if (d_op == 4'd7) st <= S_IDLE;
          else if (d_mover) st <= S_EXEC;
          else begin
            moved_q <= '0;
            st      <= S_WAIT;
          end
        end
        S_EXEC: if (mv_done) begin
          moved_q <= mv_moved;
          st      <= S_WAIT;
        end
        S_WAIT: if (!hold) st <= S_WB;
        S_WB: begin
          cmd_ptr <= take_br ? dep_q[AW-1:0] : cmd_ptr + STEP;
          st      <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_cmd_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic [AW-1:0] cmd_ptr,
  input logic          fetch_req,
  input logic          desc_valid,
  input logic [127:0]  desc_data,
  input logic          mv_req,
  input logic          mv_done,
  input logic          wb_valid,
  input logic          irq
);
  assert_one_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fetch_req, mv_req, wb_valid}) <= 1);
  assert_irq_with_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wb_valid);
  assert_wb_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
  assert_mv_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req && !mv_done |=> mv_req);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(fetch_req || mv_req || wb_valid));
  assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && desc_valid && desc_data[31:28] == 4'd7 |=> !active);
  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active && !wb_valid |=> $stable(cmd_ptr));
endmodule

bind dma_cmd_seq dma_cmd_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_dma_cmd_seq.sv
`timescale 1ns/1ps
module sim_dma_cmd_seq;
  localparam int AW = 16;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0, run_req = 0, cond = 0, desc_valid = 0, mv_done = 0;
  logic [AW-1:0] ptr_init = '0;
  logic [7:0] dev_stat = '0;
  logic [127:0] desc_data = '0;
  logic [15:0] mv_moved = '0;
  logic active, fetch_req, mv_req, wb_valid, irq;
  logic [AW-1:0] cmd_ptr, wb_addr;
  logic [2:0] mv_op, mv_key;
  logic [31:0] mv_addr, wb_data;
  logic [15:0] mv_count;

  dma_cmd_seq #(.AW(AW)) u0 (.*);

  int checks = 0, fails = 0;
  logic [AW-1:0] exp_ptr;

  task automatic check(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic bit pick(input logic [1:0] m, input logic c);
    return (m == 2'd3) || (m == 2'd1 && c) || (m == 2'd2 && !c);
  endfunction

  task automatic wait_sig(ref logic s, input string r);
    int n = 0;
    while (!s && n < 60) begin @(negedge clk); n++; end
    if (!s) check(0, r, 0, 1);
  endtask

  task automatic serve(input logic [15:0] cmd, input logic [15:0] req,
                       input logic [31:0] addr, input logic [31:0] dep);
    wait_sig(fetch_req, "R2 fetch");
    check(cmd_ptr == exp_ptr, "R8 fetch pointer", cmd_ptr, exp_ptr);
    desc_data = {32'd0, dep, addr, cmd, req};
    desc_valid = 1;
    @(negedge clk);
    desc_valid = 0;
  endtask

  task automatic do_cmd(input logic [15:0] cmd, input logic [15:0] req, input logic [31:0] addr,
                        input logic [31:0] dep, input logic [15:0] moved, input logic c,
                        input logic [7:0] ds);
    logic [3:0] op = cmd[15:12];
    logic [2:0] key = cmd[10:8];
    bit word = (op == 4) || (op == 5);
    bit mv = (op < 4) || (word && key >= 5);
    logic [15:0] cnt = word ? 16'd4 : req;
    logic [15:0] eff = mv ? moved : 16'd0;
    logic [15:0] res = (eff >= req) ? 16'd0 : req - eff;
    logic [AW-1:0] nxt = pick(cmd[3:2], c) ? dep[AW-1:0] : exp_ptr + AW'(16);
    int n = 0;
    cond = c; dev_stat = ds;
    serve(cmd, req, addr, dep);
    if (mv) begin
      wait_sig(mv_req, "R3 mover request");
      check(mv_op == op[2:0] && mv_key == key && mv_addr == addr && mv_count == cnt,
            op < 4 ? "R3 mover fields" : "R4 word fields",
            {mv_op, mv_key, mv_addr, mv_count}, {op[2:0], key, addr, cnt});
      @(negedge clk); @(negedge clk);
      check(mv_req == 1 && wb_valid == 0, "R11 hold", mv_req, 1);
      mv_moved = moved; mv_done = 1;
      @(negedge clk);
      mv_done = 0;
    end else begin
      while (!wb_valid && n < 60) begin
        if (mv_req) check(0, word ? "R4 skip mover" : "R5 skip mover", 1, 0);
        @(negedge clk); n++;
      end
    end
    wait_sig(wb_valid, "R10 writeback");
    check(wb_data == {1'b1, 7'd0, ds, res} && wb_addr == exp_ptr + AW'(12),
          "R10 writeback word", {wb_addr, wb_data}, {exp_ptr + AW'(12), 1'b1, 7'd0, ds, res});
    check(irq == pick(cmd[5:4], c), "R7 interrupt", irq, pick(cmd[5:4], c));
    exp_ptr = nxt;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!active && !fetch_req && !mv_req && !wb_valid && !irq, "R1 reset",
          {active, fetch_req, mv_req, wb_valid, irq}, 0);
    rst_n = 1;
    @(negedge clk);
    ptr_init = 16'h0100; run_req = 1;
    @(negedge clk);
    run_req = 0;
    check(active && fetch_req, "R2 start", {active, fetch_req}, 2'b11);
    exp_ptr = 16'h0100;
    // R2: run_req while active ignored
    ptr_init = 16'h3000; run_req = 1;
    @(negedge clk);
    run_req = 0;
    check(cmd_ptr == 16'h0100, "R2 ignore run", cmd_ptr, 16'h0100);

    // R3 R4 R5: all opcodes except stop, stream key 2 and register key 5
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 2; k++)
        if (op != 7)
          do_cmd({4'(op), 1'b0, (k ? 3'd5 : 3'd2), 8'h00}, 16'd40 + 16'(op),
                 32'h1000_0000 + 32'(op), 32'h0, 16'd3, 1'b0, 8'(op));

    // R7 R8: interrupt x branch x condition
    for (int i = 0; i < 4; i++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++)
          do_cmd({4'd6, 4'd0, 2'b00, 2'(i), 2'(b), 2'b00}, 16'd8, 32'h0,
                 32'h0000_0400 + 32'(i * 64 + b * 16), 16'd0, c[0], 8'h5A);

    // R10: residual variants including clamp
    do_cmd(16'h0000, 16'd100, 32'h20, 32'h0, 16'd100, 1'b0, 8'h01);
    do_cmd(16'h1000, 16'd100, 32'h20, 32'h0, 16'd37,  1'b0, 8'h02);
    do_cmd(16'h2300, 16'd100, 32'h20, 32'h0, 16'd0,   1'b0, 8'h03);
    do_cmd(16'h3000, 16'd100, 32'h20, 32'h0, 16'd120, 1'b0, 8'h04);

    // R8: wrap of the fall-through step
    do_cmd(16'h600C, 16'd0, 32'h0, 32'h0000_FFF0, 16'd0, 1'b0, 8'h00);
    check(exp_ptr == 16'hFFF0, "R8 branch target", exp_ptr, 16'hFFF0);
    do_cmd(16'h6000, 16'd0, 32'h0, 32'h0, 16'd0, 1'b0, 8'h00);
    check(exp_ptr == 16'h0000, "R8 wrap", exp_ptr, 16'h0000);

    // R9: wait while condition is 1
    cond = 1;
    serve(16'h6001, 16'd5, 32'h0, 32'h0);
    for (int n = 0; n < 20; n++) begin
      check(!wb_valid && active, "R9 wait hold", wb_valid, 0);
      @(negedge clk);
    end
    cond = 0;
    @(negedge clk);
    check(wb_valid == 1, "R9 release", wb_valid, 1);
    check(wb_data[15:0] == 16'd5, "R9 residual", wb_data[15:0], 5);
    exp_ptr = exp_ptr + AW'(16);
    @(negedge clk);

    // R6: stop, then restart
    serve(16'h7033, 16'd0, 32'h0, 32'h0);
    check(!active, "R6 stop", active, 0);
    for (int n = 0; n < 10; n++) begin
      check(!fetch_req && !wb_valid && !irq, "R6 quiet", {fetch_req, wb_valid, irq}, 0);
      @(negedge clk);
    end
    ptr_init = 16'h0800; run_req = 1;
    @(negedge clk);
    run_req = 0;
    exp_ptr = 16'h0800;
    do_cmd(16'h6030, 16'd1, 32'h0, 32'h0, 16'd0, 1'b0, 8'h77);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule